// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers event flags into a sticky status register and drives one interrupt line. Eight single-cycle event pulses arrive directly: three supply-monitor events, conversion done, FIFO full, accumulator full, and the greater-than and less-than alarms. The block also watches four analog-style and four digital general-purpose input lines. A rising or a falling edge on any of them sets its own status bit. A 24-bit mask register is active low, so a 0 lets a status bit reach the interrupt. Every mask bit comes out of reset at 1, which masks every source.

A simple register port writes the mask and marks the start and end of a status read. At the end of a read it can flag that the read was aborted. The port also carries a soft-reset strobe. When a read starts, the interrupt drops. Events that arrive while the read is open are held aside. A read that ends normally clears the status and then merges in the held events. An aborted read keeps the old status and adds the held events to it. In both cases the interrupt comes back at the end of the read if any unmasked bit is set.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, `mask_o` is 0xFFFFFF, `status_o` is 0 and the interrupt is inactive.
- R2: The interrupt is active exactly when no read is open and some status bit has a mask bit of 0. Status bits are recorded whatever the mask holds.
- R3: Event layout in `evt_i` and in status bits 23..16: `evt_i[7]` maps to bit 23 (supply A), `evt_i[6]` to 22 (supply B), `evt_i[5]` to 21 (analog supply), `evt_i[4]` to 20 (conversion done), `evt_i[3]` to 19 (FIFO full), `evt_i[2]` to 18 (accumulator full), `evt_i[1]` to 17 (greater-than) and `evt_i[0]` to 16 (less-than). A pulse sampled at a clock edge shows in `status_o` after that edge.
- R4: Edge layout: for channel c (0..3), an analog rising edge sets bit 9+2c and a digital rising edge sets bit 8+2c. An analog falling edge sets bit 1+2c and a digital falling edge sets bit 2c. Each edge is seen at the clock edge that samples the new level.
- R5: Status bits are sticky. Only a completed read or a soft reset clears them. A further event while the interrupt is active leaves it active.
- R6: The clock edge that samples `rd_start_i` makes the interrupt inactive.
- R7: While a read is open, `status_o` does not change, and new events are held aside.
- R8: A read that ends without abort sets the status to the held events plus any event in the end cycle. The interrupt reasserts if any of these is unmasked.
- R9: A read that ends with `rd_abort_i` high keeps the old status, adds the held events, and reasserts the interrupt if any unmasked bit is set.
- R10: `irq_pol_i`=1 drives `irq_o` high when active. `irq_pol_i`=0 drives it low when active.
- R11: `soft_rst_i` sets the mask to all ones, clears the status and the held events, and closes any open read, all at one edge. It overrides a mask write in the same cycle.
- R12: `rd_end_i` with no read open has no effect. A second `rd_start_i` during an open read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 8 | Single-cycle event pulses (layout in R3) |
| apio_i | input | 4 | Analog-style input lines, levels |
| dpio_i | input | 4 | Digital input lines, levels |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 24 | Mask write data, 0 = enabled |
| rd_start_i | input | 1 | Status read start strobe |
| rd_end_i | input | 1 | Status read end strobe |
| rd_abort_i | input | 1 | Qualifies `rd_end_i`: the read was aborted |
| soft_rst_i | input | 1 | Soft reset strobe |
| irq_pol_i | input | 1 | 1 = active-high interrupt, 0 = active-low |
| status_o | output | 24 | Status register |
| mask_o | output | 24 | Mask register |
| irq_o | output | 1 | Interrupt output |

## Verification
The main function is tried with single events under full masking and with single bits unmasked, which separates recording from signalling. It is also tried with stacked events, with edges on both line kinds and in both directions at once, and with reads that see no event, a masked event or an unmasked event. Completed and aborted reads are run on the same held content, so clearing is told apart from retention. Soft reset is applied during an open read, which shows that the read is closed as well as the registers cleared.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int unsigned EVT_N  = 8;
    localparam int unsigned GP_N   = 4;
    localparam int unsigned STAT_W = EVT_N + 4 * GP_N;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    typedef struct packed {
        logic [W-1:0] prev;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl_i;
        rise_o    = lvl_i & ~st_q.prev;
        fall_o    = ~lvl_i & st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irq_gp_map.sv
module irq_gp_map #(
    parameter int unsigned CH = 4
) (
    input  logic [CH-1:0]   a_rise_i,
    input  logic [CH-1:0]   d_rise_i,
    input  logic [CH-1:0]   a_fall_i,
    input  logic [CH-1:0]   d_fall_i,
    output logic [4*CH-1:0] vec_o
);
    localparam int unsigned HALF = 2 * CH;

    for (genvar c = 0; c < CH; c++) begin : g_ch
        // rising half sits above the falling half; analog above digital
        assign vec_o[HALF + 2*c + 1] = a_rise_i[c];
        assign vec_o[HALF + 2*c]     = d_rise_i[c];
        assign vec_o[2*c + 1]        = a_fall_i[c];
        assign vec_o[2*c]            = d_fall_i[c];
    end
endmodule

// File: rtl/irq_status_core.sv
module irq_status_core #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev_i,
    input  logic         rd_start_i,
    input  logic         rd_end_i,
    input  logic         rd_abort_i,
    input  logic         soft_rst_i,
    output logic [W-1:0] status_o,
    output logic         reading_o
);
    typedef struct packed {
        logic [W-1:0] status;
        logic [W-1:0] held;
        logic         reading;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (soft_rst_i) begin
            st_d = '0;
        end else if (st_q.reading) begin
            if (rd_end_i) begin
                st_d.status  = (rd_abort_i ? st_q.status : '0) | st_q.held | ev_i;
                st_d.held    = '0;
                st_d.reading = 1'b0;
            end else begin
                st_d.held = st_q.held | ev_i;
            end
        end else if (rd_start_i) begin
            st_d.reading = 1'b1;
            st_d.held    = ev_i;
        end else begin
            st_d.status = st_q.status | ev_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o  = st_q.status;
    assign reading_o = st_q.reading;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned N_EVT = EVT_N,
    parameter int unsigned N_GP  = GP_N
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_EVT-1:0]         evt_i,
    input  logic [N_GP-1:0]          apio_i,
    input  logic [N_GP-1:0]          dpio_i,
    input  logic                     mask_we_i,
    input  logic [N_EVT+4*N_GP-1:0]  mask_wdata_i,
    input  logic                     rd_start_i,
    input  logic                     rd_end_i,
    input  logic                     rd_abort_i,
    input  logic                     soft_rst_i,
    input  logic                     irq_pol_i,
    output logic [N_EVT+4*N_GP-1:0]  status_o,
    output logic [N_EVT+4*N_GP-1:0]  mask_o,
    output logic                     irq_o
);
    localparam int unsigned SW = N_EVT + 4 * N_GP;
    localparam int unsigned GW = 4 * N_GP;

    typedef struct packed {
        logic [SW-1:0] mask;
    } state_t;

    state_t st_d, st_q;

    logic [N_GP-1:0] a_rise, a_fall, d_rise, d_fall;
    logic [GW-1:0]   gp_vec;
    logic [SW-1:0]   ev_vec;
    logic            reading_q;
    logic            irq_lvl;

    irq_edge_det #(.W(N_GP)) i_edge_a (
        .clk(clk), .rst_n(rst_n), .lvl_i(apio_i), .rise_o(a_rise), .fall_o(a_fall)
    );

    irq_edge_det #(.W(N_GP)) i_edge_d (
        .clk(clk), .rst_n(rst_n), .lvl_i(dpio_i), .rise_o(d_rise), .fall_o(d_fall)
    );

    irq_gp_map #(.CH(N_GP)) i_map (
        .a_rise_i(a_rise), .d_rise_i(d_rise),
        .a_fall_i(a_fall), .d_fall_i(d_fall),
        .vec_o(gp_vec)
    );

    assign ev_vec = {evt_i, gp_vec};

    irq_status_core #(.W(SW)) i_core (
        .clk(clk), .rst_n(rst_n), .ev_i(ev_vec),
        .rd_start_i(rd_start_i), .rd_end_i(rd_end_i), .rd_abort_i(rd_abort_i),
        .soft_rst_i(soft_rst_i), .status_o(status_o), .reading_o(reading_q)
    );

    always_comb begin
        st_d = st_q;
        if (soft_rst_i)     st_d.mask = '1;
        else if (mask_we_i) st_d.mask = mask_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign mask_o  = st_q.mask;
    assign irq_lvl = !reading_q && ((status_o & ~st_q.mask) != '0);
    assign irq_o   = irq_pol_i ? irq_lvl : !irq_lvl;
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk #(
    parameter int unsigned SW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_start_i,
    input logic          rd_end_i,
    input logic          soft_rst_i,
    input logic          irq_pol_i,
    input logic          irq_o,
    input logic          reading_q,
    input logic [SW-1:0] status_o,
    input logic [SW-1:0] mask_o
);
    logic act;
    assign act = irq_pol_i ? irq_o : !irq_o;

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o & ~mask_o) == '0) |-> !act); // R2

    AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst_i && !(reading_q && rd_end_i)) |=>
        ((status_o & $past(status_o)) == $past(status_o))); // R5

    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start_i && !soft_rst_i) |=> !act); // R6

    AST_READ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (reading_q && !rd_end_i && !soft_rst_i) |=> $stable(status_o)); // R7

    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_i |=> (mask_o == '1 && status_o == '0 && !reading_q)); // R11
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(.SW(SW)) i_chk (
    .clk(clk), .rst_n(rst_n), .rd_start_i(rd_start_i), .rd_end_i(rd_end_i),
    .soft_rst_i(soft_rst_i), .irq_pol_i(irq_pol_i), .irq_o(irq_o),
    .reading_q(reading_q), .status_o(status_o), .mask_o(mask_o)
);

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt_i = '0;
    logic [3:0]  apio_i = '0, dpio_i = '0;
    logic        mask_we_i = 1'b0;
    logic [23:0] mask_wdata_i = '0;
    logic        rd_start_i = 1'b0, rd_end_i = 1'b0, rd_abort_i = 1'b0;
    logic        soft_rst_i = 1'b0, irq_pol_i = 1'b1;
    logic [23:0] status_o, mask_o;
    logic        irq_o;

    irq_status_ctrl i_irq_status_ctrl (.*);

    always #4 clk = ~clk;

    typedef struct {
        string       tag;
        logic [23:0] st;
        logic [23:0] mk;
        logic        irq;
    } item_t;

    item_t sb_q[$];
    int    n_chk = 0, n_err = 0;
    bit    done = 0;

    initial forever begin
        @(negedge clk);
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_chk++;
            if (status_o !== it.st || mask_o !== it.mk || irq_o !== it.irq) begin
                n_err++;
                $display("FAIL %s: status=%h mask=%h irq=%b expected status=%h mask=%h irq=%b",
                         it.tag, status_o, mask_o, irq_o, it.st, it.mk, it.irq);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
        evt_i = '0; mask_we_i = 0; rd_start_i = 0; rd_end_i = 0;
        rd_abort_i = 0; soft_rst_i = 0;
    endtask

    task automatic expect_state(string tag, logic [23:0] st, logic [23:0] mk, logic active);
        item_t it;
        it.tag = tag; it.st = st; it.mk = mk;
        it.irq = irq_pol_i ? active : !active;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        expect_state("R1 reset", 24'h000000, 24'hFFFFFF, 0);

        evt_i[4] = 1; tick();
        expect_state("R3 R2 done masked", 24'h100000, 24'hFFFFFF, 0);

        mask_we_i = 1; mask_wdata_i = 24'hEFFFFF; tick();
        expect_state("R2 unmask done", 24'h100000, 24'hEFFFFF, 1);

        evt_i[0] = 1; tick();
        expect_state("R5 sticky lt", 24'h110000, 24'hEFFFFF, 1);

        rd_start_i = 1; tick();
        expect_state("R6 release", 24'h110000, 24'hEFFFFF, 0);

        apio_i[2] = 1; tick();
        expect_state("R7 held", 24'h110000, 24'hEFFFFF, 0);

        rd_end_i = 1; tick();
        expect_state("R8 clear merge", 24'h002000, 24'hEFFFFF, 0);

        mask_we_i = 1; mask_wdata_i = 24'hEFDFFF; tick();
        expect_state("R2 unmask rise", 24'h002000, 24'hEFDFFF, 1);

        rd_start_i = 1; tick();
        evt_i[7] = 1; tick();
        expect_state("R7 frozen", 24'h002000, 24'hEFDFFF, 0);
        rd_end_i = 1; rd_abort_i = 1; tick();
        expect_state("R9 abort", 24'h802000, 24'hEFDFFF, 1);

        rd_start_i = 1; tick();
        evt_i[4] = 1; tick();
        expect_state("R7 frozen 2", 24'h802000, 24'hEFDFFF, 0);
        rd_end_i = 1; tick();
        expect_state("R8 reassert", 24'h100000, 24'hEFDFFF, 1);

        apio_i[2] = 0; dpio_i[0] = 1; tick();
        expect_state("R4 fall rise", 24'h100120, 24'hEFDFFF, 1);
        dpio_i[0] = 0; tick();
        expect_state("R4 dig fall", 24'h100121, 24'hEFDFFF, 1);

        irq_pol_i = 0;
        expect_state("R10 low pol", 24'h100121, 24'hEFDFFF, 1);

        rd_start_i = 1; tick();
        soft_rst_i = 1; mask_we_i = 1; mask_wdata_i = 24'h000000; tick();
        expect_state("R11 soft", 24'h000000, 24'hFFFFFF, 0);
        evt_i[1] = 1; tick();
        expect_state("R11 R3 gt after", 24'h020000, 24'hFFFFFF, 0);

        rd_end_i = 1; tick();
        expect_state("R12 stray end", 24'h020000, 24'hFFFFFF, 0);

        mask_we_i = 1; mask_wdata_i = 24'hFDFFFF; tick();
        expect_state("R10 R2 active low", 24'h020000, 24'hFDFFFF, 1);
        rd_start_i = 1; tick();
        rd_start_i = 1; tick();
        expect_state("R12 double start", 24'h020000, 24'hFDFFFF, 0);
        rd_end_i = 1; tick();
        expect_state("R8 plain clear", 24'h000000, 24'hFDFFFF, 0);

        @(negedge clk); #1;
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule